// File: doc/BRIEF.md
# Microcoded Load/Store Control Sequencer

This block is the microprogrammed controller for a small 32-bit RISC datapath. It walks a micro-PC through a microcode store that is built into the block. Each instruction starts with a common prologue, in which the sequencer latches the instruction, decodes it and bumps the program counter by four. A switch step then jumps to a micro-routine chosen by the opcode. Only load and store have routines. Every other opcode returns straight to the first micro-instruction.

Each micro-step raises exactly one control strobe on a one-hot bus, and the datapath reads that bus. The load routine reads the base register into operand A. It moves the immediate into operand B and adds, loads the MAR from the ALU result, and reads memory. It then presents the loaded word as write data and writes the destination register. The store routine forms the address in the same way. It then reads the source register into a memory-data register and issues a memory write. Both memory steps hold until `mem_ready` is high.

Top module: `ldst_useq`

## Requirements
- R1: Reset is synchronous and active high. A cycle with `rst` high at a rising edge leaves `upc_o` = 0 and `stb_o` = 12'h001. This applies in the middle of a routine too.
- R2: Every instruction begins with micro-addresses 0, 1 and 2 on consecutive cycles, then reaches address 3. The strobes are bit 0 (latch instruction), bit 1 (decode), bit 2 (PC plus 4) and bit 3 (switch).
- R3: The opcode is `instr_in[31:27]`, sampled at the edge that ends address 0. Opcode 5'd14 (load) sends the switch step to address 4, and opcode 5'd15 (store) sends it to address 10.
- R4: The load routine visits addresses 4 to 9 in order and then returns to 0. Its strobes are bit 4 (read rs1 into A), bit 5 (immediate into B, add), bit 6 (MAR from ALU), bit 7 (memory read), bit 8 (load data to write port) and bit 9 (write rd).
- R5: The store routine visits addresses 10 to 14 in order and then returns to 0. Its strobes are bits 4, 5 and 6, then bit 10 (read rd into memory-data register), then bit 11 (memory write). Bit 9 is never raised during a store.
- R6: Any opcode other than 14 or 15 returns from the switch step to address 0. The whole instruction takes 4 cycles.
- R7: On a memory step (bit 7 or bit 11), the micro-PC holds while `mem_ready` is low. It advances at the first edge where `mem_ready` is high.
- R8: `stb_o` has exactly one bit set in every cycle.
- R9: A change of `instr_in` at any time other than the edge that ends address 0 has no effect on where the switch step goes.
- R10: `mem_ready` has no effect outside the memory steps. A non-memory step always advances after one cycle, even when `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_in | input | 32 | Instruction word from instruction memory |
| mem_ready | input | 1 | Data memory has completed the current access |
| upc_o | output | 4 | Current micro-PC |
| stb_o | output | 12 | One-hot control strobe of the current micro-step |

## Verification
`upc_o` is a register. `stb_o` is decoded from it without further registers, so both change one rising edge after the inputs that were sampled at that edge. The bench drives `instr_in` and `mem_ready` on falling edges. A behavioural model advances on every rising edge, and the bench compares both outputs against it on the next falling edge, so each result is checked in the cycle it is due. Per-instruction cycle totals are also checked: 4 cycles for an unknown opcode, 10 plus the stall cycles for a load, and 9 plus the stall cycles for a store. These totals show that stalls happen only on memory steps, and that late changes to `instr_in` have no effect.

// File: rtl/ldst_useq_pkg.sv
package ldst_useq_pkg;

    localparam int UPC_W  = 4;
    localparam int NSTB   = 12;
    localparam int OP_W   = $clog2(NSTB);

    // entry points of the two routines
    localparam logic [UPC_W-1:0] A_FETCH = 4'd0;
    localparam logic [UPC_W-1:0] A_LOAD  = 4'd4;
    localparam logic [UPC_W-1:0] A_STORE = 4'd10;

    // strobe index == bit position on the strobe bus
    typedef enum logic [OP_W-1:0] {
        OP_IR_LATCH  = 4'd0,
        OP_DECODE    = 4'd1,
        OP_PC_ADD4   = 4'd2,
        OP_SWITCH    = 4'd3,
        OP_SRC_TO_A  = 4'd4,
        OP_IMM_ADD   = 4'd5,
        OP_ADDR_MAR  = 4'd6,
        OP_MEM_READ  = 4'd7,
        OP_LD_WDATA  = 4'd8,
        OP_RD_WRITE  = 4'd9,
        OP_RD_TO_MDR = 4'd10,
        OP_MEM_WRITE = 4'd11
    } uop_e;

    typedef enum logic [1:0] {
        SQ_STEP,
        SQ_DISPATCH,
        SQ_RETURN
    } seq_e;

    typedef struct packed {
        uop_e op;
        logic hold_mem;
        seq_e seq;
    } uword_t;

endpackage

// File: rtl/ldst_useq_rom.sv
module ldst_useq_rom
    import ldst_useq_pkg::*;
(
    input  logic [UPC_W-1:0] addr_i,
    output uword_t           word_o
);

    always_comb begin
        word_o = '{op: OP_IR_LATCH, hold_mem: 1'b0, seq: SQ_RETURN};
        case (addr_i)
            // common prologue
            4'd0:  word_o = '{op: OP_IR_LATCH,  hold_mem: 1'b0, seq: SQ_STEP};
            4'd1:  word_o = '{op: OP_DECODE,    hold_mem: 1'b0, seq: SQ_STEP};
            4'd2:  word_o = '{op: OP_PC_ADD4,   hold_mem: 1'b0, seq: SQ_STEP};
            4'd3:  word_o = '{op: OP_SWITCH,    hold_mem: 1'b0, seq: SQ_DISPATCH};
            // load routine
            4'd4:  word_o = '{op: OP_SRC_TO_A,  hold_mem: 1'b0, seq: SQ_STEP};
            4'd5:  word_o = '{op: OP_IMM_ADD,   hold_mem: 1'b0, seq: SQ_STEP};
            4'd6:  word_o = '{op: OP_ADDR_MAR,  hold_mem: 1'b0, seq: SQ_STEP};
            4'd7:  word_o = '{op: OP_MEM_READ,  hold_mem: 1'b1, seq: SQ_STEP};
            4'd8:  word_o = '{op: OP_LD_WDATA,  hold_mem: 1'b0, seq: SQ_STEP};
            4'd9:  word_o = '{op: OP_RD_WRITE,  hold_mem: 1'b0, seq: SQ_RETURN};
            // store routine
            4'd10: word_o = '{op: OP_SRC_TO_A,  hold_mem: 1'b0, seq: SQ_STEP};
            4'd11: word_o = '{op: OP_IMM_ADD,   hold_mem: 1'b0, seq: SQ_STEP};
            4'd12: word_o = '{op: OP_ADDR_MAR,  hold_mem: 1'b0, seq: SQ_STEP};
            4'd13: word_o = '{op: OP_RD_TO_MDR, hold_mem: 1'b0, seq: SQ_STEP};
            4'd14: word_o = '{op: OP_MEM_WRITE, hold_mem: 1'b1, seq: SQ_RETURN};
            default: ;
        endcase
    end

endmodule

// File: rtl/ldst_useq_disp.sv
module ldst_useq_disp
    import ldst_useq_pkg::*;
#(
    parameter int               OPC_W  = 5,
    parameter logic [OPC_W-1:0] LD_OPC = 5'd14,
    parameter logic [OPC_W-1:0] ST_OPC = 5'd15
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic [UPC_W-1:0] target_o
);

    always_comb begin
        if (opc_i == LD_OPC)      target_o = A_LOAD;
        else if (opc_i == ST_OPC) target_o = A_STORE;
        else                      target_o = A_FETCH;
    end

endmodule

// File: rtl/ldst_useq_stbdec.sv
module ldst_useq_stbdec
    import ldst_useq_pkg::*;
(
    input  uop_e            op_i,
    output logic [NSTB-1:0] stb_o
);

    for (genvar g = 0; g < NSTB; g++) begin : g_bit
        localparam logic [OP_W-1:0] CODE = g[OP_W-1:0];
        assign stb_o[g] = (op_i == uop_e'(CODE));
    end

endmodule

// File: rtl/ldst_useq.sv
module ldst_useq
    import ldst_useq_pkg::*;
#(
    parameter int               INSTR_W = 32,
    parameter int               OPC_W   = 5,
    parameter int               OPC_LSB = 27,
    parameter logic [OPC_W-1:0] LD_OPC  = 5'd14,
    parameter logic [OPC_W-1:0] ST_OPC  = 5'd15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic               mem_ready,
    output logic [UPC_W-1:0]   upc_o,
    output logic [NSTB-1:0]    stb_o
);

    typedef struct packed {
        logic [UPC_W-1:0] upc;
        logic [OPC_W-1:0] opc;
    } state_t;

    state_t           s_d, s_q;
    uword_t           word;
    logic [UPC_W-1:0] disp_tgt;
    logic             may_go;

    ldst_useq_rom u_rom (
        .addr_i (s_q.upc),
        .word_o (word)
    );

    ldst_useq_disp #(
        .OPC_W  (OPC_W),
        .LD_OPC (LD_OPC),
        .ST_OPC (ST_OPC)
    ) u_disp (
        .opc_i    (s_q.opc),
        .target_o (disp_tgt)
    );

    ldst_useq_stbdec u_dec (
        .op_i  (word.op),
        .stb_o (stb_o)
    );

    always_comb begin
        s_d    = s_q;
        may_go = !word.hold_mem || mem_ready;
        if (word.op == OP_IR_LATCH) begin
            s_d.opc = instr_in[OPC_LSB +: OPC_W];
        end
        case (word.seq)
            SQ_STEP:     if (may_go) s_d.upc = s_q.upc + 1'b1;
            SQ_DISPATCH: s_d.upc = disp_tgt;
            SQ_RETURN:   if (may_go) s_d.upc = A_FETCH;
            default:     s_d.upc = A_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign upc_o = s_q.upc;

    // ---------------- assertions ----------------
    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (upc_o == A_FETCH));

    p_prologue_r2: assert property (@(posedge clk) disable iff (rst)
        (upc_o == 4'd0) |=> (upc_o == 4'd1));

    p_disp_load_r3: assert property (@(posedge clk) disable iff (rst)
        (stb_o[OP_SWITCH] && s_q.opc == LD_OPC) |=> (upc_o == A_LOAD));

    p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
        (upc_o >= A_STORE) |-> !stb_o[OP_RD_WRITE]);

    p_other_return_r6: assert property (@(posedge clk) disable iff (rst)
        (stb_o[OP_SWITCH] && s_q.opc != LD_OPC && s_q.opc != ST_OPC)
        |=> (upc_o == A_FETCH));

    p_mem_stall_r7: assert property (@(posedge clk) disable iff (rst)
        ((stb_o[OP_MEM_READ] || stb_o[OP_MEM_WRITE]) && !mem_ready)
        |=> $stable(upc_o));

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(stb_o) == 1);

    p_no_stall_elsewhere_r10: assert property (@(posedge clk) disable iff (rst)
        (!stb_o[OP_MEM_READ] && !stb_o[OP_MEM_WRITE]) |=> !$stable(upc_o));

endmodule

// File: tb/sim_ldst_useq.sv
module sim_ldst_useq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_in = 32'h0;
    logic        mem_ready = 1'b0;
    logic [3:0]  upc_o;
    logic [11:0] stb_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int m_upc  = 0;
    int m_opc  = 0;

    localparam int LD = 14;
    localparam int ST = 15;

    always #2 clk = ~clk;   // 250 MHz

    ldst_useq u0 (
        .clk       (clk),
        .rst       (rst),
        .instr_in  (instr_in),
        .mem_ready (mem_ready),
        .upc_o     (upc_o),
        .stb_o     (stb_o)
    );

    // behavioural reference: which strobe bit each micro-address raises
    function automatic int exp_bit(input int u);
        case (u)
            4, 10:   return 4;
            5, 11:   return 5;
            6, 12:   return 6;
            13:      return 10;
            14:      return 11;
            default: return u;
        endcase
    endfunction

    function automatic string region(input int u);
        if (u < 3)       return "R2";
        else if (u == 3) return "R3";
        else if (u < 10) return "R4";
        else             return "R5";
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_upc <= 0;
            m_opc <= 0;
        end else begin
            case (m_upc)
                0: begin m_opc <= int'(instr_in[31:27]); m_upc <= 1; end
                3: m_upc <= (m_opc == LD) ? 4 : (m_opc == ST) ? 10 : 0;
                7: m_upc <= mem_ready ? 8 : 7;
                9: m_upc <= 0;
                14: m_upc <= mem_ready ? 0 : 14;
                default: m_upc <= m_upc + 1;
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        string t;
        t = rst ? "R1" : region(m_upc);
        checks++;
        if (int'(upc_o) !== m_upc) begin
            fails++;
            $display("FAIL %s upc: actual %0d expected %0d", t, upc_o, m_upc);
        end
        checks++;
        if (stb_o !== (12'h001 << exp_bit(m_upc))) begin
            fails++;
            $display("FAIL %s strobe: actual %h expected %h", t, stb_o,
                     12'h001 << exp_bit(m_upc));
        end
        checks++;
        if ($countones(stb_o) != 1) begin
            fails++;
            $display("FAIL R8 one-hot: actual %h expected one bit", stb_o);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // run one instruction from address 0 back to address 0
    task automatic run_instr(input int opc, input int stall, input bit scramble,
                             input string tag);
        int n = 0;
        int waits = 0;
        int expn;
        instr_in = {opc[4:0], 27'h2A5_1C3};
        do begin
            @(negedge clk);
            n++;
            if (scramble && m_upc == 1) instr_in = {5'd3, 27'h0};   // R9
            if (m_upc == 7 || m_upc == 14) begin
                mem_ready = (waits >= stall);
                waits++;
            end else begin
                mem_ready = 1'b0;   // R10: low elsewhere
            end
        end while (m_upc != 0);
        expn = (opc == LD) ? 10 + stall : (opc == ST) ? 9 + stall : 4;
        check_eq(tag, n, expn);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 reset upc", int'(upc_o), 0);
        check_eq("R1 reset strobe", int'(stb_o), 1);
        rst = 1'b0;

        run_instr(LD, 0, 1'b0, "R4 load cycles");
        run_instr(LD, 3, 1'b0, "R7 load stall cycles");
        run_instr(ST, 0, 1'b0, "R5 store cycles");
        run_instr(ST, 2, 1'b0, "R7 store stall cycles");
        run_instr(3,  0, 1'b0, "R6 other opcode cycles");
        run_instr(0,  0, 1'b0, "R6 zero opcode cycles");
        run_instr(LD, 1, 1'b1, "R9 load with late instr change");
        run_instr(ST, 1, 1'b1, "R9 store with late instr change");
        run_instr(31, 0, 1'b0, "R10 other opcode, ready low");

        // R1: reset in the middle of a load routine
        instr_in = {5'd14, 27'h0};
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 mid-routine reset upc", int'(upc_o), 0);
        rst = 1'b0;
        run_instr(ST, 0, 1'b0, "R5 store after reset");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule